// File: doc/BRIEF.md
# Timer Power-Management Configuration Controller

This block holds the configuration word of a timer peripheral and runs the peripheral's side of the system power-management handshake. Software writes the word over a simple register bus: a one-cycle write strobe with address and data, and a combinational read path. The word holds a two-bit idle policy, a bit that lets the timer keep running under debug suspend, and a self-clearing soft-reset trigger.

The idle policy decides how the block answers the system's idle request. It can acknowledge at once, never acknowledge, acknowledge only once the timer core reports no pending work, or do the same and also raise a wakeup request while idle. A freeze output stops the timer counter while the debug suspend input is active, unless the run-free bit is set. A write of 1 to the trigger bit starts a fixed four-cycle internal reset. During that reset the bit reads back 1 and the configuration fields return to zero.

Top module: `tmr_pm_ctrl`

## Requirements
- R1: After `rst_n` is released, the configuration word reads 0, and `idle_ack`, `wake_req` and `core_rst` are low.
- R2: A read at address 0x10 returns the idle policy in bits 3:2, the run-free bit in bit 1 and the reset-busy flag in bit 0, with bits 31:4 zero. A read at any other address returns 0. Reads are combinational.
- R3: A write to any address other than 0x10 leaves the configuration unchanged. A write at 0x10 while a soft reset is running is also ignored.
- R4: With policy 0 (forced), `idle_ack` goes high on the cycle after `idle_req` is sampled high, whatever the value of `core_busy`.
- R5: With policy 1 (never), `idle_ack` stays low.
- R6: With policy 2 or 3 (smart), `idle_ack` rises only on the cycle after `idle_req` is sampled high together with `core_busy` low. Busy seen before that point keeps the acknowledge held off. Once the acknowledge is given, it holds until the request drops.
- R7: In every policy, `idle_ack` is low on the cycle after `idle_req` is sampled low.
- R8: With policy 3, `wake_req` is high on the cycle after a sample where `idle_ack`, `idle_req` and `wake_evt` are all high. With any other policy, `wake_req` stays low.
- R9: `freeze` equals `suspend_in` when the run-free bit is 0, and is 0 when the run-free bit is 1. It reacts within the same cycle.
- R10: A write of a word with bit 0 set starts a soft reset. For the next 4 cycles `core_rst` and the busy flag are 1, and the policy and run-free fields read 0. A write with bit 0 clear only updates the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| idle_req | input | 1 | System idle request |
| core_busy | input | 1 | Timer core has pending work |
| wake_evt | input | 1 | Interrupt or DMA event from the core |
| suspend_in | input | 1 | Debug suspend, active high |
| idle_ack | output | 1 | Idle acknowledge |
| wake_req | output | 1 | Wakeup request |
| freeze | output | 1 | Stop the timer counter |
| core_rst | output | 1 | Module-internal soft reset |

## Verification
A wrong handshake state shows up on `idle_ack` one cycle after the request or busy sample that should have moved it. A stale acknowledge also corrupts `wake_req` on the following cycle. A wrong policy or run-free field is visible at once on the read data and on `freeze`. A miscounted soft reset shows up on `core_rst` and the busy bit at the fourth or fifth cycle after the trigger write. The bench drives random bus, request, busy, event and suspend traffic and compares every output on every cycle, so each fault surfaces within one or two cycles of the stimulus that exposes it.

// File: rtl/tmr_pm_pkg.sv
package tmr_pm_pkg;

    typedef enum logic [1:0] {
        IDLE_FORCE      = 2'd0,
        IDLE_NEVER      = 2'd1,
        IDLE_SMART      = 2'd2,
        IDLE_SMART_WAKE = 2'd3
    } idle_pol_e;

    typedef enum logic [1:0] {
        HS_RUN  = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

endpackage

// File: rtl/tmr_pm_cfg_reg.sv
module tmr_pm_cfg_reg
    import tmr_pm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CFG_ADDR    = 'h10,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output idle_pol_e         mode,
    output logic              run_free,
    output logic              srst_busy
);
    localparam int CNT_W = $clog2(SRST_CYCLES + 1);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);

    typedef struct packed {
        idle_pol_e        mode;
        logic             run_free;
        logic [CNT_W-1:0] cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:4];
    assign hit             = (addr == HIT_ADDR);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_q.cnt != '0) begin
            cfg_d.cnt      = cfg_q.cnt - CNT_W'(1);
            cfg_d.mode     = IDLE_FORCE;
            cfg_d.run_free = 1'b0;
        end else if (wr && hit) begin
            if (wdata[0]) begin
                cfg_d.cnt      = CNT_W'(SRST_CYCLES);
                cfg_d.mode     = IDLE_FORCE;
                cfg_d.run_free = 1'b0;
            end else begin
                cfg_d.mode     = idle_pol_e'(wdata[3:2]);
                cfg_d.run_free = wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: IDLE_FORCE, run_free: 1'b0, cnt: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode      = cfg_q.mode;
    assign run_free  = cfg_q.run_free;
    assign srst_busy = (cfg_q.cnt != '0);

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[3:0] = {cfg_q.mode, cfg_q.run_free, srst_busy};
        end
    end

endmodule

// File: rtl/tmr_pm_idle_fsm.sv
module tmr_pm_idle_fsm
    import tmr_pm_pkg::*;
#(
    parameter bit WAKE_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  idle_pol_e mode,
    input  logic      idle_req,
    input  logic      core_busy,
    input  logic      wake_evt,
    output logic      idle_ack,
    output logic      wake_req
);
    typedef struct packed {
        hs_state_e st;
        logic      wake;
    } hs_t;

    hs_t  hs_d, hs_q;
    logic wake_ok;

    generate
        if (WAKE_EN) begin : g_wake
            assign wake_ok = (mode == IDLE_SMART_WAKE);
        end else begin : g_nowake
            assign wake_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        hs_d = hs_q;
        unique case (mode)
            IDLE_FORCE: hs_d.st = idle_req ? HS_ACK : HS_RUN;
            IDLE_NEVER: hs_d.st = HS_RUN;
            default: begin
                if (!idle_req) begin
                    hs_d.st = HS_RUN;
                end else if (hs_q.st == HS_ACK) begin
                    hs_d.st = HS_ACK;
                end else if (!core_busy) begin
                    hs_d.st = HS_ACK;
                end else begin
                    hs_d.st = HS_WAIT;
                end
            end
        endcase
        hs_d.wake = wake_ok && (hs_q.st == HS_ACK) && idle_req && wake_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{st: HS_RUN, wake: 1'b0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign idle_ack = (hs_q.st == HS_ACK);
    assign wake_req = hs_q.wake;

endmodule

// File: rtl/tmr_pm_ctrl.sv
module tmr_pm_ctrl
    import tmr_pm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CFG_ADDR    = 'h10,
    parameter int SRST_CYCLES = 4,
    parameter bit WAKE_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              idle_req,
    input  logic              core_busy,
    input  logic              wake_evt,
    input  logic              suspend_in,
    output logic              idle_ack,
    output logic              wake_req,
    output logic              freeze,
    output logic              core_rst
);
    idle_pol_e cfg_mode;
    logic      cfg_run_free;
    logic      cfg_srst;

    tmr_pm_cfg_reg #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CFG_ADDR   (CFG_ADDR),
        .SRST_CYCLES(SRST_CYCLES)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .mode     (cfg_mode),
        .run_free (cfg_run_free),
        .srst_busy(cfg_srst)
    );

    tmr_pm_idle_fsm #(
        .WAKE_EN(WAKE_EN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_mode),
        .idle_req (idle_req),
        .core_busy(core_busy),
        .wake_evt (wake_evt),
        .idle_ack (idle_ack),
        .wake_req (wake_req)
    );

    assign freeze   = suspend_in && !cfg_run_free;
    assign core_rst = cfg_srst;

endmodule

// File: rtl/tmr_pm_ctrl_chk.sv
module tmr_pm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_run_free,
    input logic       idle_req,
    input logic       core_busy,
    input logic       idle_ack,
    input logic       wake_req,
    input logic       freeze,
    input logic       core_rst
);
    // R4
    force_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && idle_req) |=> idle_ack);

    // R5
    never_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1) |=> !idle_ack);

    // R6
    smart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1] && idle_req && core_busy && !idle_ack) |=> !idle_ack);

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> !idle_ack);

    // R8
    wake_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(idle_ack) && $past(cfg_mode) == 2'd3));

    // R9
    run_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_run_free |-> !freeze);

    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (cfg_mode == 2'd0 && !cfg_run_free));

endmodule

bind tmr_pm_ctrl tmr_pm_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_run_free(cfg_run_free),
    .idle_req    (idle_req),
    .core_busy   (core_busy),
    .idle_ack    (idle_ack),
    .wake_req    (wake_req),
    .freeze      (freeze),
    .core_rst    (core_rst)
);

// File: tb/tmr_pm_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_pm_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        idle_req = 1'b0;
    logic        core_busy = 1'b0;
    logic        wake_evt = 1'b0;
    logic        suspend_in = 1'b0;
    logic        idle_ack, wake_req, freeze, core_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected state, derived from the requirements
    logic [1:0] m_mode = 2'd0;
    logic       m_free = 1'b0;
    int         m_cnt  = 0;
    int         m_st   = 0;   // 0 run, 1 waiting, 2 acknowledged
    logic       m_wake = 1'b0;
    string      ack_tag = "R4";

    always #2 clk = ~clk;

    tmr_pm_ctrl u_tmr_pm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_req(idle_req),
        .core_busy(core_busy), .wake_evt(wake_evt), .suspend_in(suspend_in),
        .idle_ack(idle_ack), .wake_req(wake_req), .freeze(freeze), .core_rst(core_rst)
    );

    function automatic logic [31:0] exp_rdata(logic [7:0] a);
        if (a == 8'h10) return {28'd0, m_mode, m_free, (m_cnt != 0)};
        return 32'd0;
    endfunction

    function automatic logic exp_freeze();
        return suspend_in && !m_free;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(bus_rdata == exp_rdata(bus_addr), "R2", bus_rdata, exp_rdata(bus_addr));
        check(idle_ack == (m_st == 2), ack_tag, 32'(idle_ack), 32'(m_st == 2));
        check(wake_req == m_wake, "R8", 32'(wake_req), 32'(m_wake));
        check(freeze == exp_freeze(), "R9", 32'(freeze), 32'(exp_freeze()));
        check(core_rst == (m_cnt != 0), "R10", 32'(core_rst), 32'(m_cnt != 0));
    endtask

    task automatic tick();
        logic [1:0] n_mode = m_mode;
        logic       n_free = m_free;
        int         n_cnt  = m_cnt;
        int         n_st;
        logic       n_wake;
        if (m_cnt > 0) begin
            n_cnt = m_cnt - 1; n_mode = 2'd0; n_free = 1'b0;
        end else if (bus_wr && bus_addr == 8'h10) begin
            if (bus_wdata[0]) begin
                n_cnt = 4; n_mode = 2'd0; n_free = 1'b0;
            end else begin
                n_mode = bus_wdata[3:2]; n_free = bus_wdata[1];
            end
        end
        case (m_mode)
            2'd0:    n_st = idle_req ? 2 : 0;
            2'd1:    n_st = 0;
            default: n_st = !idle_req ? 0 : (m_st == 2 || !core_busy) ? 2 : 1;
        endcase
        n_wake = (m_mode == 2'd3) && (m_st == 2) && idle_req && wake_evt;
        @(posedge clk);
        @(negedge clk);
        m_mode = n_mode; m_free = n_free; m_cnt = n_cnt; m_st = n_st; m_wake = n_wake;
        compare_all();
    endtask

    task automatic wr_cfg(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        suspend_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(bus_rdata == 32'd0, "R1", bus_rdata, 0);
        check(!idle_ack && !wake_req && !core_rst, "R1", {idle_ack, wake_req, core_rst}, 0);
        check(freeze == 1'b1, "R9", 32'(freeze), 1);

        // R2 field layout and other-address reads
        wr_cfg(8'h10, 32'hFFFF_FF06);
        bus_addr = 8'h10; #1;
        check(bus_rdata == 32'h6, "R2", bus_rdata, 32'h6);
        check(freeze == 1'b0, "R9", 32'(freeze), 0);
        bus_addr = 8'h14; #1;
        check(bus_rdata == 32'd0, "R2", bus_rdata, 0);
        // R3 write elsewhere ignored
        wr_cfg(8'h14, 32'h0000_000C);
        bus_addr = 8'h10; #1;
        check(bus_rdata == 32'h6, "R3", bus_rdata, 32'h6);

        // R5 never acknowledge
        wr_cfg(8'h10, 32'h4);
        check(freeze == 1'b1, "R9", 32'(freeze), 1);
        ack_tag = "R5";
        idle_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            check(!idle_ack, "R5", 32'(idle_ack), 0);
        end

        // R4 forced acknowledge despite busy
        ack_tag = "R4";
        core_busy = 1'b1;
        wr_cfg(8'h10, 32'h0);
        tick();
        check(idle_ack, "R4", 32'(idle_ack), 1);
        ack_tag = "R7";
        idle_req = 1'b0;
        tick();
        check(!idle_ack, "R7", 32'(idle_ack), 0);

        // R6 smart policy
        ack_tag = "R6";
        wr_cfg(8'h10, 32'h8);
        idle_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(!idle_ack, "R6", 32'(idle_ack), 0);
        end
        core_busy = 1'b0;
        tick();
        check(idle_ack, "R6", 32'(idle_ack), 1);
        core_busy = 1'b1;
        tick();
        check(idle_ack, "R6", 32'(idle_ack), 1);
        wake_evt = 1'b1;
        tick();
        check(!wake_req, "R8", 32'(wake_req), 0);
        idle_req = 1'b0; wake_evt = 1'b0;
        tick();
        check(!idle_ack, "R7", 32'(idle_ack), 0);

        // R8 wakeup policy
        wr_cfg(8'h10, 32'hC);
        core_busy = 1'b0; idle_req = 1'b1;
        tick();
        wake_evt = 1'b1;
        tick();
        check(wake_req, "R8", 32'(wake_req), 1);
        wake_evt = 1'b0;
        tick();
        check(!wake_req, "R8", 32'(wake_req), 0);
        idle_req = 1'b0;
        tick();

        // R10 soft reset sequence, R3 write during it ignored
        ack_tag = "R6";
        wr_cfg(8'h10, 32'hF);
        check(bus_rdata == 32'h1 && core_rst, "R10", bus_rdata, 32'h1);
        wr_cfg(8'h10, 32'h6);
        check(bus_rdata == 32'h1, "R3", bus_rdata, 32'h1);
        tick();
        tick();
        check(core_rst, "R10", 32'(core_rst), 1);
        tick();
        check(bus_rdata == 32'h0 && !core_rst, "R10", bus_rdata, 32'h0);
        wr_cfg(8'h10, 32'h8);
        check(bus_rdata == 32'h8 && !core_rst, "R10", bus_rdata, 32'h8);

        // random traffic against the expected model
        ack_tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            bus_wr     = ($urandom_range(0, 3) == 0);
            bus_addr   = ($urandom_range(0, 7) == 0) ? 8'(($urandom_range(0, 63)) << 2) : 8'h10;
            bus_wdata  = $urandom() & 32'hFFFF_FFFE;
            if ($urandom_range(0, 15) == 0) bus_wdata[0] = 1'b1;
            idle_req   = ($urandom_range(0, 3) != 0);
            core_busy  = ($urandom_range(0, 2) == 0);
            wake_evt   = ($urandom_range(0, 1) == 0);
            suspend_in = ($urandom_range(0, 1) == 0);
            tick();
        end

        done = 1'b1;
        finish_run();
    end

endmodule